// File: doc/BRIEF.md
# SATA Link Idle Arbiter

This block is the idle-state controller for the host end of a serial ATA link layer. From its idle state it picks the next activity. That activity can be a frame transmission that the transport layer asked for, a frame reception that the far end asked for, or a power-mode change asked for by the transport layer or by PHY control. When a local transmit request and a far-end frame request arrive together, the host gives way: the receive sequencer starts first, and the transmit request stays pending.

The block keeps a registered copy of PHY ready. It reports each rising and falling edge to the transport layer as a one-cycle pulse. While the registered PHY ready is low, the controller stays in its not-ready state and withdraws any grant in progress. Grants are level handshakes. They are held until the matching sequencer reports that it is done.

Top module: `sata_link_idle_arb`

## Requirements
- R1: After reset, state_o is 6'b000001 (not ready), and tx_start_o, rx_start_o, pm_req_o, rdy_rise_o and rdy_fall_o are all low.
- R2: One clock edge after phy_rdy_i goes high, rdy_rise_o is high for exactly one cycle. One edge later, state_o is 6'b000010 (idle).
- R3: In idle, with tx_req_i high and rx_req_i low, the next state is 6'b000100. tx_start_o stays high until an edge that samples tx_done_i high, and that edge returns the block to idle.
- R4: In idle, with rx_req_i and tx_req_i both high, the next state is 6'b001000 and only rx_start_o is high. A tx_req_i that is still high is granted in the first idle cycle that has no far-end request.
- R5: rx_start_o stays high, even after rx_req_i falls, until an edge that samples rx_done_i high. That edge returns the block to idle.
- R6: In idle, with pm_en_i high, a request on pm_req_tl_i or pm_req_pc_i moves the block to 6'b010000 with pm_req_o high. pm_ack_i then moves it to 6'b100000, and pm_done_i returns it to idle.
- R7: While pm_en_i is low, power-mode requests are ignored: the block stays in idle and pm_req_o stays low.
- R8: In idle, a frame request on tx_req_i or rx_req_i takes priority over a power-mode request.
- R9: One edge after phy_rdy_i falls, rdy_fall_o pulses for one cycle. One edge later, the state is 6'b000001 and every grant is low. No grant starts while PHY ready stays low.
- R10: state_o is always one-hot: bit 0 not ready, bit 1 idle, bit 2 transmit grant, bit 3 receive grant, bit 4 power request, bit 5 power active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phy_rdy_i | input | 1 | PHY ready |
| tx_req_i | input | 1 | Transport transmit request, held until granted |
| rx_req_i | input | 1 | Far-end frame request detected |
| tx_done_i | input | 1 | Transmit sequencer finished |
| rx_done_i | input | 1 | Receive sequencer finished |
| pm_en_i | input | 1 | Power-mode change enable |
| pm_req_tl_i | input | 1 | Power-mode request from transport |
| pm_req_pc_i | input | 1 | Power-mode request from PHY control |
| pm_ack_i | input | 1 | Power change accepted |
| pm_done_i | input | 1 | Power mode exited |
| tx_start_o | output | 1 | Transmit grant |
| rx_start_o | output | 1 | Receive grant |
| pm_req_o | output | 1 | Power-mode change request |
| rdy_rise_o | output | 1 | PHY ready rose (pulse) |
| rdy_fall_o | output | 1 | PHY ready fell (pulse) |
| state_o | output | 6 | One-hot controller state |

## Verification
The hardest case to reach is a transmit request that was deferred by a coincident far-end request and must be granted later. Reaching it takes a receive grant that is held open, released through rx_done_i, and checked one cycle at a time while tx_req_i stays high. A second hard case is a PHY ready drop in the middle of a grant: the grant must survive exactly the one cycle of register latency and then vanish. A far-end request made while not ready must then produce no grant.

// File: rtl/sata_lidle_pkg.sv
package sata_lidle_pkg;
  localparam int NUM_ST = 6;
  localparam int ST_W   = NUM_ST;

  typedef enum logic [ST_W-1:0] {
    ST_NRDY = 6'b000001,
    ST_IDLE = 6'b000010,
    ST_GTX  = 6'b000100,
    ST_GRX  = 6'b001000,
    ST_PMRQ = 6'b010000,
    ST_PMON = 6'b100000
  } lidle_st_e;
endpackage

// File: rtl/sata_lidle_rdy_edge.sv
module sata_lidle_rdy_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  output logic rdy_q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], rdy_i};
  end

  assign rdy_q_o = sh_q[0];
  assign rise_o  = sh_q[0] & ~sh_q[1];
  assign fall_o  = ~sh_q[0] & sh_q[1];

  p_rise_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_fall_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sata_lidle_pm_gate.sv
module sata_lidle_pm_gate #(
  parameter int N_SRC = 2
) (
  input  logic             en_i,
  input  logic [N_SRC-1:0] req_i,
  output logic             valid_o
);
  // enable gates every source
  assign valid_o = en_i & (|req_i);
endmodule

// File: rtl/sata_lidle_fsm.sv
module sata_lidle_fsm
  import sata_lidle_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rdy_i,
  input  logic            tx_req_i,
  input  logic            rx_req_i,
  input  logic            tx_done_i,
  input  logic            rx_done_i,
  input  logic            pm_valid_i,
  input  logic            pm_ack_i,
  input  logic            pm_done_i,
  output logic [ST_W-1:0] st_o
);
  lidle_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!rdy_i) st_d = ST_NRDY;
    else begin
      case (st_q)
        ST_NRDY: st_d = ST_IDLE;
        ST_IDLE: begin
          if (rx_req_i)        st_d = ST_GRX;  // host yields
          else if (tx_req_i)   st_d = ST_GTX;
          else if (pm_valid_i) st_d = ST_PMRQ;
        end
        ST_GTX:  if (tx_done_i) st_d = ST_IDLE;
        ST_GRX:  if (rx_done_i) st_d = ST_IDLE;
        ST_PMRQ: if (pm_ack_i)  st_d = ST_PMON;
        ST_PMON: if (pm_done_i) st_d = ST_IDLE;
        default: st_d = ST_NRDY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_NRDY;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(st_q) == 1);
  p_host_yields_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && rdy_i && rx_req_i) |=> st_q == ST_GRX);
  p_tx_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && rdy_i && tx_req_i && !rx_req_i) |=> st_q == ST_GTX);
  p_rx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GRX && rdy_i && !rx_done_i) |=> st_q == ST_GRX);
  p_pm_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !pm_valid_i) |=> st_q != ST_PMRQ);
  p_unready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_i |=> st_q == ST_NRDY);
endmodule

// File: rtl/sata_link_idle_arb.sv
module sata_link_idle_arb
  import sata_lidle_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            phy_rdy_i,
  input  logic            tx_req_i,
  input  logic            rx_req_i,
  input  logic            tx_done_i,
  input  logic            rx_done_i,
  input  logic            pm_en_i,
  input  logic            pm_req_tl_i,
  input  logic            pm_req_pc_i,
  input  logic            pm_ack_i,
  input  logic            pm_done_i,
  output logic            tx_start_o,
  output logic            rx_start_o,
  output logic            pm_req_o,
  output logic            rdy_rise_o,
  output logic            rdy_fall_o,
  output logic [ST_W-1:0] state_o
);
  logic rdy_q, pm_valid;
  logic [ST_W-1:0] st;

  sata_lidle_rdy_edge #(.STAGES(2)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .rdy_i(phy_rdy_i),
    .rdy_q_o(rdy_q), .rise_o(rdy_rise_o), .fall_o(rdy_fall_o)
  );

  sata_lidle_pm_gate #(.N_SRC(2)) u_pm (
    .en_i(pm_en_i), .req_i({pm_req_pc_i, pm_req_tl_i}), .valid_o(pm_valid)
  );

  sata_lidle_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .rdy_i(rdy_q),
    .tx_req_i(tx_req_i), .rx_req_i(rx_req_i),
    .tx_done_i(tx_done_i), .rx_done_i(rx_done_i),
    .pm_valid_i(pm_valid), .pm_ack_i(pm_ack_i), .pm_done_i(pm_done_i),
    .st_o(st)
  );

  assign state_o    = st;
  assign tx_start_o = (st == ST_GTX);
  assign rx_start_o = (st == ST_GRX);
  assign pm_req_o   = (st == ST_PMRQ);

  p_excl_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({tx_start_o, rx_start_o, pm_req_o}) <= 1);
endmodule

// File: tb/sata_link_idle_arb_test.sv
`timescale 1ns/100ps
module sata_link_idle_arb_test;
  logic clk = 0, rst_n = 0;
  logic phy_rdy = 0, tx_req = 0, rx_req = 0, tx_done = 0, rx_done = 0;
  logic pm_en = 0, pm_tl = 0, pm_pc = 0, pm_ack = 0, pm_done = 0;
  logic tx_start, rx_start, pm_req, rise, fall;
  logic [5:0] state;
  int total = 0, bad = 0;
  bit finished = 0;

  localparam logic [5:0] S_NRDY = 6'd1, S_IDLE = 6'd2, S_GTX = 6'd4,
                         S_GRX = 6'd8, S_PMRQ = 6'd16, S_PMON = 6'd32;

  always #2.5 clk = ~clk;

  sata_link_idle_arb uut (
    .clk_i(clk), .rst_ni(rst_n), .phy_rdy_i(phy_rdy),
    .tx_req_i(tx_req), .rx_req_i(rx_req), .tx_done_i(tx_done), .rx_done_i(rx_done),
    .pm_en_i(pm_en), .pm_req_tl_i(pm_tl), .pm_req_pc_i(pm_pc),
    .pm_ack_i(pm_ack), .pm_done_i(pm_done),
    .tx_start_o(tx_start), .rx_start_o(rx_start), .pm_req_o(pm_req),
    .rdy_rise_o(rise), .rdy_fall_o(fall), .state_o(state)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic t_reset();
    step();
    chk(state, S_NRDY, "R1 state");
    chk({tx_start, rx_start, pm_req, rise, fall}, 0, "R1 outputs");
    rst_n = 1; step();
  endtask

  task automatic t_ready_up();
    phy_rdy = 1; step();
    chk(rise, 1, "R2 rise pulse");
    chk(state, S_NRDY, "R2 still not ready");
    step();
    chk(rise, 0, "R2 pulse one cycle");
    chk(state, S_IDLE, "R2 idle");
  endtask

  task automatic t_tx();
    tx_req = 1; step();
    chk(tx_start, 1, "R3 tx grant");
    tx_req = 0; step();
    chk(tx_start, 1, "R3 grant held");
    tx_done = 1; step(); tx_done = 0;
    chk(state, S_IDLE, "R3 back idle");
  endtask

  task automatic t_coincide();
    tx_req = 1; rx_req = 1; step();
    chk({tx_start, rx_start}, 2'b01, "R4 host yields");
    rx_req = 0; step();
    chk(rx_start, 1, "R5 rx held");
    rx_done = 1; step(); rx_done = 0;
    chk(state, S_IDLE, "R5 rx done idle");
    step();
    chk(tx_start, 1, "R4 pending tx granted");
    tx_req = 0; tx_done = 1; step(); tx_done = 0;
    chk(state, S_IDLE, "R4 tx done idle");
  endtask

  task automatic t_pm(input bit from_pc);
    pm_en = 1; pm_tl = !from_pc; pm_pc = from_pc; step();
    chk(pm_req, 1, "R6 pm request");
    chk(state, S_PMRQ, "R6 pm req state");
    pm_tl = 0; pm_pc = 0; pm_ack = 1; step(); pm_ack = 0;
    chk(state, S_PMON, "R6 pm active");
    chk(pm_req, 0, "R6 pm req dropped");
    pm_done = 1; step(); pm_done = 0;
    chk(state, S_IDLE, "R6 pm exit");
  endtask

  task automatic t_pm_off();
    pm_en = 0; pm_tl = 1; pm_pc = 1; step(); step();
    chk(state, S_IDLE, "R7 ignored state");
    chk(pm_req, 0, "R7 no pm req");
    pm_tl = 0; pm_pc = 0;
  endtask

  task automatic t_priority();
    pm_en = 1; pm_pc = 1; tx_req = 1; step();
    chk(state, S_GTX, "R8 frame before pm");
    pm_pc = 0; tx_req = 0; tx_done = 1; step(); tx_done = 0;
    chk(state, S_IDLE, "R8 idle");
  endtask

  task automatic t_drop();
    tx_req = 1; step();
    chk(tx_start, 1, "R9 grant before drop");
    tx_req = 0; phy_rdy = 0; step();
    chk(fall, 1, "R9 fall pulse");
    chk(tx_start, 1, "R9 latency cycle");
    step();
    chk(fall, 0, "R9 pulse one cycle");
    chk(state, S_NRDY, "R9 not ready");
    chk(tx_start, 0, "R9 grant withdrawn");
    rx_req = 1; step(); step();
    chk(rx_start, 0, "R9 no grant while unready");
    chk(state, S_NRDY, "R9 stays not ready");
    rx_req = 0;
  endtask

  initial begin
    t_reset();
    t_ready_up();
    t_tx();
    t_coincide();
    t_pm(0);
    t_pm(1);
    t_pm_off();
    t_priority();
    t_drop();
    t_ready_up();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule